// File: doc/BRIEF.md
# Store-and-Forward Packet FIFO

This block buffers packets on a transmit path in front of a link core that must receive every packet as one unbroken burst. Beats are 64-bit words marked with start-of-packet and end-of-packet flags. They enter through a valid/ready sink and leave through a valid/ready source. Both sides use ready latency 0: a beat moves on every rising clock edge where valid and ready are both high.

A packet is never offered on the source until its final beat has been written into storage. The output is gated by a count of complete packets that have not yet begun to leave. A packet starts only when this count is nonzero, so all of its beats are already resident when it starts. From its first offered beat to its last, source valid stays high on every cycle, whatever the sink side is doing.

Storage is a single-clock memory that can map onto block RAM, with a registered read port feeding the source. Writes and reads can happen in the same cycle at full rate. A packet too long to fit cannot complete, which leaves the block blocked. A sticky error flag reports this until reset.

Top module: `sf_pkt_fifo`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `out_valid` is 0, `in_ready` is 1 and `overflow` is 0.
- R2: No beat of a packet is offered on the source before the beat carrying `in_eop`=1 of that packet has been accepted. When the source is idle, the first beat of a packet is offered on the second clock edge after the edge that accepts its end-of-packet beat.
- R3: Once the first beat of a packet has been offered, `out_valid` stays 1 on every cycle until the beat with `out_eop`=1 is accepted, independent of `in_valid`.
- R4: While `out_valid` is 1 and `out_ready` is 0, the offered beat (`out_data`, `out_sop`, `out_eop`) holds unchanged on the next cycle.
- R5: Beats leave in the order they were accepted, with the 64-bit data and both packet markers unchanged.
- R6: `in_ready` is 0 exactly while DEPTH beats are held in storage. A write and a read in the same cycle are both accepted, so a stream with the source always ready never sees `in_ready` fall.
- R7: If storage is full, no complete packet is waiting, and no packet is part-way out, `overflow` rises on the next edge and stays 1 until reset. No beat of the unfinished packet is offered.
- R8: A packet of exactly DEPTH beats is accepted whole and forwarded intact without raising `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sink beat valid |
| in_ready | output | 1 | Sink can accept a beat |
| in_data | input | DATA_W | Sink beat data |
| in_sop | input | 1 | Sink beat is first of packet |
| in_eop | input | 1 | Sink beat is last of packet |
| out_valid | output | 1 | Source beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Source beat data |
| out_sop | output | 1 | Source beat is first of packet |
| out_eop | output | 1 | Source beat is last of packet |
| overflow | output | 1 | Sticky flag: a packet exceeded storage |

## Verification
The hardest condition to reach is storage that fills while packet state is mixed. The case that matters is an outgoing packet stalled mid-burst while a partial next packet keeps arriving. There, the block must keep valid high without starving, and it must not falsely flag overflow.

Random phases reach this condition by pairing a bursty sink with a source that is rarely ready, using packet lengths up to the full depth. Directed sequences cover the exact exposure latency, a packet of exactly full depth behind a stalled source, concurrent streaming, and a packet longer than storage that must trip the sticky flag.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned PFQ_DATA_W = 64;

  typedef struct packed {
    logic sop;
    logic eop;
  } pfq_mark_t;

  localparam int unsigned PFQ_MARK_W = $bits(pfq_mark_t);
endpackage

// File: rtl/pfq_ram.sv
module pfq_ram #(
  parameter int unsigned W     = 66,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // synchronous write and registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfq_ptrs.sv
module pfq_ptrs #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0]   OCC_MAX  = (AW+1)'(DEPTH);

  logic [AW:0] occ;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr <= '0;
      raddr <= '0;
      occ   <= '0;
    end else begin
      if (wr_en) waddr <= bump(waddr);
      if (rd_en) raddr <= bump(raddr);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == OCC_MAX);
  assign empty = (occ == '0);

  // R6: storage never holds more than DEPTH beats
  a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_MAX);

  // R5: a read is only issued when a stored beat exists
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (occ != '0));
endmodule

// File: rtl/pfq_gate.sv
module pfq_gate #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic eop_wr,    // end-of-packet beat written this cycle
  input  logic start_rd,  // first beat of a packet leaves storage
  input  logic full,
  input  logic mid,       // a packet is part-way out
  output logic have_pkt,
  output logic overflow
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [CW-1:0] cnt;  // complete packets not yet started

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      case ({eop_wr, start_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (full && (cnt == '0) && !mid) overflow <= 1'b1;
    end
  end

  assign have_pkt = (cnt != '0);

  // R2: a packet start is only taken from a nonzero complete count
  a_r2_start_has_pkt: assert property (@(posedge clk) disable iff (rst)
    start_rd |-> (cnt != '0));

  // R7: the error flag stays set until reset
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8: complete packets never exceed the number of stored beats
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
endmodule

// File: rtl/sf_pkt_fifo.sv
module sf_pkt_fifo #(
  parameter int unsigned DATA_W = pfq_pkg::PFQ_DATA_W,
  parameter int unsigned DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              overflow
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned BW = DATA_W + pfq_pkg::PFQ_MARK_W;

  pfq_pkg::pfq_mark_t wr_mark, rd_mark;
  logic [BW-1:0]      wr_word, rd_word;
  logic [AW-1:0]      waddr, raddr;
  logic               full, empty, have_pkt;
  logic               wr, pop, mid, start_rd;

  assign in_ready = !full;
  assign wr       = in_valid && !full;

  assign wr_mark  = '{sop: in_sop, eop: in_eop};
  assign wr_word  = {wr_mark, in_data};

  // a packet is in flight while a non-final beat sits on the source
  assign mid      = out_valid && !out_eop;
  assign pop      = !empty && (mid || have_pkt) && (!out_valid || out_ready);
  assign start_rd = pop && !mid;

  pfq_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr),
    .rd_en (pop),
    .waddr (waddr),
    .raddr (raddr),
    .full  (full),
    .empty (empty)
  );

  pfq_ram #(.W(BW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr),
    .waddr (waddr),
    .wdata (wr_word),
    .re    (pop),
    .raddr (raddr),
    .rdata (rd_word)
  );

  pfq_gate #(.DEPTH(DEPTH), .CW(CW)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .eop_wr   (wr && in_eop),
    .start_rd (start_rd),
    .full     (full),
    .mid      (mid),
    .have_pkt (have_pkt),
    .overflow (overflow)
  );

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (pop)       out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  assign rd_mark  = rd_word[BW-1 -: pfq_pkg::PFQ_MARK_W];
  assign out_data = rd_word[DATA_W-1:0];
  assign out_sop  = rd_mark.sop;
  assign out_eop  = rd_mark.eop;

  // R3: no bubble inside a packet on the source
  a_r3_hold_mid: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |=> out_valid);

  // R4: stalled beat is held
  a_r4_stall_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_eop) && $stable(out_sop)));

  // R6: sink is refused only while storage is full
  a_r6_ready_room: assert property (@(posedge clk) disable iff (rst)
    (!in_ready) |-> !empty);
endmodule

// File: tb/test_sf_pkt_fifo.sv
module test_sf_pkt_fifo;
  localparam int DEPTH = 16;
  localparam int W     = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid, out_sop, out_eop, overflow;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  always #5 clk = ~clk;

  sf_pkt_fifo #(.DATA_W(W), .DEPTH(DEPTH)) i_sf_pkt_fifo (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .overflow(overflow)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [W+1:0] exp_q[$];
  logic [W+1:0] pend_q[$];
  int  completed = 0, started = 0;
  bit  in_pkt = 0, prev_stall = 0;
  logic [W+1:0] stall_beat;
  bit  obs_v, obs_r, obs_o, fired_in, fired_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W+1:0] mk_beat(input bit s, input bit e);
    return {s, e, $urandom(), $urandom()};
  endfunction

  task automatic add_pkt(input int len);
    for (int i = 0; i < len; i++) pend_q.push_back(mk_beat(i == 0, i == len - 1));
  endtask

  // one clock cycle, everything observed and driven at the falling edge
  task automatic step(input int vin_pct, input int rdy_pct);
    logic [W+1:0] got, exp;
    @(negedge clk);
    obs_v = out_valid; obs_r = in_ready; obs_o = overflow;
    got = {out_sop, out_eop, out_data};
    if (in_pkt) chk(out_valid == 1'b1, "R3", "valid dropped mid-packet", out_valid, 1);
    if (prev_stall) chk(out_valid && got == stall_beat, "R4", "stalled beat changed", got, stall_beat);
    if (out_valid && !in_pkt) begin
      chk(completed > started, "R2", "packet offered before its end was written", started, completed);
      started++;
      in_pkt = 1;
    end
    out_ready = (($urandom() % 100) < rdy_pct);
    fired_out = out_valid && out_ready;
    if (fired_out) begin
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      chk(got == exp, "R5", "beat mismatch", got, exp);
      if (out_eop) in_pkt = 0;
    end
    prev_stall = out_valid && !out_ready;
    stall_beat = got;
    in_valid = (pend_q.size() > 0) && (($urandom() % 100) < vin_pct);
    if (pend_q.size() > 0) {in_sop, in_eop, in_data} = pend_q[0];
    fired_in = in_valid && in_ready;
    if (fired_in) begin
      exp_q.push_back(pend_q.pop_front());
      if (in_eop) completed++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    pend_q.delete(); exp_q.delete();
    completed = 0; started = 0; in_pkt = 0; prev_stall = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 1 && overflow == 0, "R1", "state during reset",
        {out_valid, in_ready, overflow}, 3'b010);
    rst = 1'b0;
    chk(out_valid == 0 && in_ready == 1 && overflow == 0, "R1", "state after reset",
        {out_valid, in_ready, overflow}, 3'b010);
  endtask

  task automatic drain(input int rdy_pct);
    int guard = 0;
    while ((exp_q.size() > 0 || pend_q.size() > 0) && guard < 4000) begin
      step(100, rdy_pct);
      guard++;
    end
    chk(exp_q.size() == 0, "R5", "beats left undelivered", exp_q.size(), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R5 watchdog expired: actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int both;
    void'($urandom(32'h5eed_0042));
    do_reset();

    // R2 exposure latency on an idle source
    add_pkt(1);
    step(100, 100);
    chk(fired_in == 1, "R2", "single-beat packet accepted", fired_in, 1);
    step(0, 100);
    chk(obs_v == 0, "R2", "valid one edge after end written", obs_v, 0);
    step(0, 100);
    chk(obs_v == 1, "R2", "valid two edges after end written", obs_v, 1);
    drain(100);

    // R8 / R6: full-depth packet behind a stalled source
    add_pkt(DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      step(100, 0);
      chk(obs_r == 1, "R6", "ready while room remains", obs_r, 1);
    end
    step(0, 0);
    chk(obs_r == 0, "R6", "ready low with DEPTH beats stored", obs_r, 0);
    chk(obs_v == 0, "R2", "no beat before first pop", obs_v, 0);
    step(0, 0);
    chk(obs_r == 1, "R6", "ready back after beat moved out", obs_r, 1);
    chk(obs_v == 1, "R8", "full-depth packet offered", obs_v, 1);
    chk(obs_o == 0, "R8", "no overflow for full-depth packet", obs_o, 0);
    drain(100);

    // R6: concurrent write and read at full rate
    both = 0;
    for (int p = 0; p < 3; p++) add_pkt(5);
    for (int i = 0; i < 26; i++) begin
      step(100, 100);
      chk(obs_r == 1, "R6", "ready held while streaming", obs_r, 1);
      if (fired_in && fired_out) both++;
    end
    chk(both >= 5, "R6", "cycles with write and read together", both, 5);
    chk(exp_q.size() == 0 && pend_q.size() == 0, "R6", "stream finished in time",
        exp_q.size() + pend_q.size(), 0);

    // random phases: (input rate, output ready rate)
    for (int ph = 0; ph < 4; ph++) begin
      int vin = (ph == 0) ? 70 : (ph == 1) ? 100 : (ph == 2) ? 30 : 100;
      int rdy = (ph == 0) ? 70 : (ph == 1) ? 25  : (ph == 2) ? 100 : 100;
      for (int p = 0; p < 60; p++) begin
        add_pkt(1 + ($urandom() % DEPTH));
        while (pend_q.size() > 0) step(vin, rdy);
      end
      drain(60);
    end

    // R7: packet longer than storage
    do_reset();
    add_pkt(DEPTH + 3);
    for (int i = 0; i < DEPTH; i++) step(100, 100);
    chk(obs_o == 0, "R7", "no flag before storage fills", obs_o, 0);
    step(100, 100);
    chk(obs_r == 0, "R6", "ready low when storage full", obs_r, 0);
    step(100, 100);
    chk(obs_o == 1, "R7", "overflow raised", obs_o, 1);
    chk(obs_v == 0, "R7", "unfinished packet not offered", obs_v, 0);
    repeat (4) step(0, 100);
    chk(obs_o == 1, "R7", "overflow sticky", obs_o, 1);
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule